// File: doc/BRIEF.md
# Operand Address and Branch Target Generator

This block works out where an 8-bit processor's operand lives and where a branch goes. After the opcode has been fetched, the sequencer hands it an addressing-mode code, the address of the opcode, and the already evaluated branch condition. The block then reads the bytes that follow the opcode over a byte-wide read port. It returns the 16-bit effective address or the immediate value, whether a branch is part of the instruction, whether it is taken, and the program counter of the next instruction. The whole machine uses one linear 64 KB space, so every address is 16 bits wide and all address arithmetic wraps modulo 65536.

Eight mode codes are handled. Four are plain operand modes: no operand, 8-bit immediate, 16-bit immediate and direct page. One is a plain relative branch. Three are compare/test-and-branch forms. In these the first byte after the opcode locates the tested operand and the last byte is always a relative branch offset. A request is accepted with a one-cycle `start` pulse while `busy` is low. One cycle of `done` marks the moment the results are valid. The results then hold until the next request completes.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 0 (no operand) issues no memory read. It completes with ea_valid=0, imm_valid=0, br_valid=0, br_taken=0, ea=0, imm=0 and next_pc=pc+1.
- R2: Mode code 1 (8-bit immediate) reads one byte at pc+1. It gives imm={8'h00, byte}, imm_valid=1, ea_valid=0 and next_pc=pc+2.
- R3: Mode code 2 (16-bit immediate) reads pc+1 first and pc+2 second, on consecutive cycles. The first byte is the high byte: imm={byte(pc+1), byte(pc+2)}, and next_pc=pc+3. All byte addresses wrap modulo 65536.
- R4: Mode code 3 (direct page) reads one byte d at pc+1. It gives ea_valid=1 and ea={8'h00, d}, which covers 0x0000 to 0x00FF, and next_pc=pc+2.
- R5: Mode code 4 (relative) reads a signed offset at pc+1. When cond is 1, next_pc=(pc+2)+sign_extend(offset) mod 65536 and br_taken=1.
- R6: In every branch mode, cond=0 gives br_taken=0 and next_pc equal to the address after the instruction. Non-branch modes always give br_valid=0 and br_taken=0.
- R7: Mode codes 5 (direct operand and branch) and 6 (8-bit immediate and branch) take the operand from pc+1 and the offset from pc+2. The fall-through address is pc+3. Mode code 7 (no operand and branch) takes the offset from pc+1, and its fall-through address is pc+2. Mode codes 4 to 7 give br_valid=1.
- R8: busy rises on the edge that accepts start and falls on the edge that raises done. A start pulse while busy is high is ignored.
- R9: done pulses for one cycle at 1, 3 or 4 clock edges after the accepting edge, for 0, 1 or 2 operand bytes. At most one read is requested per cycle, and none in the cycle done is high. Read data is taken from mem_rdata one cycle after the request.
- R10: After reset, busy, done, mem_req and every result output are 0.
- R11: The result outputs hold their values after done until the next request completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted while busy is low |
| mode | input | 3 | Addressing-mode code (0..7) |
| pc | input | 16 | Address of the opcode byte |
| cond | input | 1 | Branch condition for branch modes |
| busy | output | 1 | Request in progress |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_req |
| done | output | 1 | One-cycle pulse: results valid |
| ea_valid | output | 1 | Effective address present |
| ea | output | 16 | Effective address |
| imm_valid | output | 1 | Immediate value present |
| imm | output | 16 | Immediate value |
| br_valid | output | 1 | Instruction carries a relative branch |
| br_taken | output | 1 | Branch taken |
| next_pc | output | 16 | Program counter of the next instruction |

## Verification
The bench sweeps all eight modes against offsets 0x7F and 0x80, small offsets of both signs, and direct bytes 0x00 and 0xFF, at opcode addresses near zero and near the top of memory. A design that zero-extended the offset would send 0x80 forward instead of back 128 bytes. A wrong 16-bit byte order would show up as a swapped immediate. A carry leaking into the page byte would put a direct address outside page zero, and a missing wrap would break targets and fetch addresses next to 0xFFFF. Separate runs pulse start in the middle of a request and watch the outputs for several idle cycles, which exposes a design that restarts or lets its results drift.

// File: rtl/opag_pkg.sv
package opag_pkg;

   typedef enum logic [2:0] {
      AM_NONE    = 3'd0,
      AM_IMM8    = 3'd1,
      AM_IMM16   = 3'd2,
      AM_PAGE    = 3'd3,
      AM_REL     = 3'd4,
      AM_PAGE_BR = 3'd5,
      AM_IMM_BR  = 3'd6,
      AM_NONE_BR = 3'd7
   } amode_e;

   // number of bytes that follow the opcode
   function automatic logic [1:0] tail_bytes(amode_e m);
      case (m)
         AM_NONE:                       tail_bytes = 2'd0;
         AM_IMM16, AM_PAGE_BR, AM_IMM_BR: tail_bytes = 2'd2;
         default:                       tail_bytes = 2'd1;
      endcase
   endfunction

   function automatic logic carries_branch(amode_e m);
      carries_branch = (m == AM_REL) || (m == AM_PAGE_BR) ||
                       (m == AM_IMM_BR) || (m == AM_NONE_BR);
   endfunction

   function automatic logic gives_address(amode_e m);
      gives_address = (m == AM_PAGE) || (m == AM_PAGE_BR);
   endfunction

   function automatic logic gives_immediate(amode_e m);
      gives_immediate = (m == AM_IMM8) || (m == AM_IMM16) || (m == AM_IMM_BR);
   endfunction

endpackage

// File: rtl/opag_rel_adder.sv
module opag_rel_adder #(
   parameter int AW          = 16,
   parameter int DW          = 8,
   parameter bit CARRY_CHAIN = 1'b0
) (
   input  logic [AW-1:0] base,
   input  logic [DW-1:0] offset,
   output logic [AW-1:0] sum
);
   localparam int EXT = AW - DW;

   logic [AW-1:0] wide_off;
   assign wide_off = {{EXT{offset[DW-1]}}, offset};

   generate
      if (CARRY_CHAIN) begin : g_chain
         logic [AW-1:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < AW; i++) begin : g_bit
            assign sum[i] = base[i] ^ wide_off[i] ^ cy[i];
            if (i < AW - 1) begin : g_cy
               assign cy[i+1] = (base[i] & wide_off[i]) |
                                (cy[i] & (base[i] ^ wide_off[i]));
            end
         end
      end else begin : g_plain
         assign sum = base + wide_off;
      end
   endgenerate

endmodule

// File: rtl/opag_fetch.sv
module opag_fetch
   import opag_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  amode_e        mode,
   input  logic [AW-1:0] pc,
   input  logic          cond,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic          finish,
   output amode_e        mode_q,
   output logic [AW-1:0] pc_q,
   output logic          cond_q,
   output logic [DW-1:0] byte0,
   output logic [DW-1:0] byte1
);
   logic [1:0] need;
   logic [1:0] issued;
   logic [1:0] got;
   logic       pend;

   assign need     = tail_bytes(mode_q);
   assign mem_req  = busy && (issued != need);
   assign mem_addr = pc_q + AW'(issued) + AW'(1);
   assign finish   = busy && (got == need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         mode_q <= AM_NONE;
         pc_q   <= '0;
         cond_q <= 1'b0;
         issued <= '0;
         got    <= '0;
         pend   <= 1'b0;
         byte0  <= '0;
         byte1  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            mode_q <= mode;
            pc_q   <= pc;
            cond_q <= cond;
            issued <= '0;
            got    <= '0;
            pend   <= 1'b0;
         end
      end else begin
         pend <= mem_req;
         if (mem_req)
            issued <= issued + 2'd1;
         if (pend) begin
            if (got == 2'd0) byte0 <= mem_rdata;
            else             byte1 <= mem_rdata;
            got <= got + 2'd1;
         end
         if (finish)
            busy <= 1'b0;
      end
   end

endmodule

// File: rtl/opag_assemble.sv
module opag_assemble
   import opag_pkg::*;
#(
   parameter int          AW          = 16,
   parameter int          DW          = 8,
   parameter logic [7:0]  PAGE_HI     = 8'h00,
   parameter bit          CARRY_CHAIN = 1'b0
) (
   input  amode_e        mode_q,
   input  logic [AW-1:0] pc_q,
   input  logic          cond_q,
   input  logic [DW-1:0] byte0,
   input  logic [DW-1:0] byte1,
   output logic          ea_v,
   output logic [AW-1:0] ea_n,
   output logic          imm_v,
   output logic [AW-1:0] imm_n,
   output logic          br_v,
   output logic          taken_n,
   output logic [AW-1:0] next_n
);
   localparam int EXT = AW - DW;

   logic [1:0]    nb;
   logic [AW-1:0] fall;
   logic [DW-1:0] offset;
   logic [AW-1:0] target;

   assign nb     = tail_bytes(mode_q);
   assign fall   = pc_q + AW'(nb) + AW'(1);
   // offset is always the last byte after the opcode
   assign offset = (nb == 2'd2) ? byte1 : byte0;

   opag_rel_adder #(.AW(AW), .DW(DW), .CARRY_CHAIN(CARRY_CHAIN)) u_add (
      .base  (fall),
      .offset(offset),
      .sum   (target)
   );

   always_comb begin
      ea_v    = gives_address(mode_q);
      imm_v   = gives_immediate(mode_q);
      br_v    = carries_branch(mode_q);
      ea_n    = ea_v ? {PAGE_HI[EXT-1:0], byte0} : '0;
      if (!imm_v)
         imm_n = '0;
      else if (mode_q == AM_IMM16)
         imm_n = {byte0, byte1};
      else
         imm_n = {{EXT{1'b0}}, byte0};
      taken_n = br_v && cond_q;
      next_n  = taken_n ? target : fall;
   end

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
   import opag_pkg::*;
#(
   parameter int         AW          = 16,
   parameter int         DW          = 8,
   parameter logic [7:0] PAGE_HI     = 8'h00,
   parameter bit         CARRY_CHAIN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    mode,
   input  logic [AW-1:0] pc,
   input  logic          cond,
   output logic          busy,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_rdata,
   output logic          done,
   output logic          ea_valid,
   output logic [AW-1:0] ea,
   output logic          imm_valid,
   output logic [AW-1:0] imm,
   output logic          br_valid,
   output logic          br_taken,
   output logic [AW-1:0] next_pc
);
   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("address width must be twice the data width");
      end
      if (AW - DW > 8) begin : g_bad_page
         $error("page byte parameter too narrow");
      end
   endgenerate

   amode_e        mode_q;
   logic [AW-1:0] pc_q;
   logic          cond_q;
   logic [DW-1:0] byte0, byte1;
   logic          finish;
   logic          ea_v, imm_v, br_v, taken_n;
   logic [AW-1:0] ea_n, imm_n, next_n;

   opag_fetch #(.AW(AW), .DW(DW)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mode     (amode_e'(mode)),
      .pc       (pc),
      .cond     (cond),
      .mem_rdata(mem_rdata),
      .busy     (busy),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .finish   (finish),
      .mode_q   (mode_q),
      .pc_q     (pc_q),
      .cond_q   (cond_q),
      .byte0    (byte0),
      .byte1    (byte1)
   );

   opag_assemble #(.AW(AW), .DW(DW), .PAGE_HI(PAGE_HI),
                   .CARRY_CHAIN(CARRY_CHAIN)) u_asm (
      .mode_q (mode_q),
      .pc_q   (pc_q),
      .cond_q (cond_q),
      .byte0  (byte0),
      .byte1  (byte1),
      .ea_v   (ea_v),
      .ea_n   (ea_n),
      .imm_v  (imm_v),
      .imm_n  (imm_n),
      .br_v   (br_v),
      .taken_n(taken_n),
      .next_n (next_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         ea_valid  <= 1'b0;
         ea        <= '0;
         imm_valid <= 1'b0;
         imm       <= '0;
         br_valid  <= 1'b0;
         br_taken  <= 1'b0;
         next_pc   <= '0;
      end else begin
         done <= finish;
         if (finish) begin
            ea_valid  <= ea_v;
            ea        <= ea_n;
            imm_valid <= imm_v;
            imm       <= imm_n;
            br_valid  <= br_v;
            br_taken  <= taken_n;
            next_pc   <= next_n;
         end
      end
   end

endmodule

// File: rtl/opag_checker.sv
module opag_checker
   import opag_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [2:0]    mode,
   input logic [AW-1:0] pc,
   input logic          busy,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          done,
   input logic          ea_valid,
   input logic [AW-1:0] ea,
   input logic          imm_valid,
   input logic          br_valid,
   input logic          br_taken,
   input logic [AW-1:0] next_pc
);
   localparam int EXT = AW - DW;

   amode_e        ck_mode;
   logic [AW-1:0] ck_pc;
   logic [AW-1:0] ck_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_mode <= AM_NONE;
         ck_pc   <= '0;
      end else if (start && !busy) begin
         ck_mode <= amode_e'(mode);
         ck_pc   <= pc;
      end
   end

   assign ck_len = AW'(tail_bytes(ck_mode)) + AW'(1);

   assert_fetch_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr == ck_pc + AW'(1)) || (mem_addr == ck_pc + AW'(2)));

   assert_read_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy && !done);

   assert_no_operand_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ck_mode == AM_NONE) |->
         !ea_valid && !imm_valid && !br_valid && (next_pc == ck_pc + AW'(1)));

   assert_page_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ck_mode == AM_PAGE) |-> ea_valid && (ea[AW-1:DW] == EXT'(0)));

   assert_fall_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !br_taken) |-> (next_pc == ck_pc + ck_len));

   assert_branch_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (br_valid == ck_mode[2]));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(next_pc) || done);

endmodule

bind opaddr_gen opag_checker #(.AW(AW), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .mode     (mode),
   .pc       (pc),
   .busy     (busy),
   .mem_req  (mem_req),
   .mem_addr (mem_addr),
   .done     (done),
   .ea_valid (ea_valid),
   .ea       (ea),
   .imm_valid(imm_valid),
   .br_valid (br_valid),
   .br_taken (br_taken),
   .next_pc  (next_pc)
);

// File: tb/opaddr_gen_test.sv
`timescale 1ns/1ps
module opaddr_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic [15:0] pc = 16'h0;
   logic        cond = 1'b0;
   logic        busy, mem_req, done, ea_valid, imm_valid, br_valid, br_taken;
   logic [15:0] mem_addr, ea, imm, next_pc;
   logic [7:0]  mem_rdata = 8'h00;

   always #2.5 clk = ~clk;

   opaddr_gen uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc(pc),
      .cond(cond), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .done(done), .ea_valid(ea_valid), .ea(ea),
      .imm_valid(imm_valid), .imm(imm), .br_valid(br_valid),
      .br_taken(br_taken), .next_pc(next_pc)
   );

   int checks = 0;
   int fails  = 0;

   // memory model: bytes after the opcode
   logic [15:0] cur_pc = 16'h0;
   logic [7:0]  x1 = 8'h0, x2 = 8'h0;
   int          reads = 0;
   int          bad_addr = 0;
   logic [15:0] first_addr = 16'h0;

   always @(posedge clk) begin
      if (mem_req) begin
         if (reads == 0) first_addr = mem_addr;
         reads = reads + 1;
         if (mem_addr == cur_pc + 16'd1)      mem_rdata <= x1;
         else if (mem_addr == cur_pc + 16'd2) mem_rdata <= x2;
         else begin
            mem_rdata <= 8'hEE;
            bad_addr = bad_addr + 1;
         end
      end else begin
         mem_rdata <= 8'h00;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      #(150000 * 5);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
   end

   // issue a request, wait for done, return latency in negedges
   task automatic issue(input logic [2:0] m, input logic [15:0] p,
                        input logic [7:0] a, input logic [7:0] b,
                        input logic c, output int lat);
      cur_pc = p; x1 = a; x2 = b; reads = 0; bad_addr = 0;
      @(negedge clk);
      mode = m; pc = p; cond = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 12) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic run_one(input logic [2:0] m, input logic [15:0] p,
                          input logic [7:0] a, input logic [7:0] b,
                          input logic c);
      int          n, lat;
      logic        e_eav, e_imv, e_brv, e_tk;
      logic [15:0] e_ea, e_imm, fall, e_next;
      logic [7:0]  off;
      case (m)
         3'd0:             n = 0;
         3'd2, 3'd5, 3'd6: n = 2;
         default:          n = 1;
      endcase
      fall   = p + 16'(n) + 16'd1;
      off    = (n == 2) ? b : a;
      e_eav  = (m == 3'd3) || (m == 3'd5);
      e_ea   = e_eav ? {8'h00, a} : 16'h0;
      e_imv  = (m == 3'd1) || (m == 3'd2) || (m == 3'd6);
      e_imm  = !e_imv ? 16'h0 : (m == 3'd2) ? {a, b} : {8'h00, a};
      e_brv  = m[2];
      e_tk   = e_brv && c;
      e_next = e_tk ? fall + {{8{off[7]}}, off} : fall;

      issue(m, p, a, b, c, lat);
      chk("R9 latency", lat, (n == 0) ? 2 : n + 3);
      chk("R9 read count", reads, n);
      chk("R3 read address range", bad_addr, 0);
      if (n == 2) chk("R3 first read at pc+1", first_addr, p + 16'd1);
      if (m == 3'd0) chk("R1 no operand outputs", {ea_valid, imm_valid, br_valid, br_taken, ea, imm}, 0);
      chk("R4 ea_valid", ea_valid, e_eav);
      chk("R4 direct ea", ea, e_ea);
      chk("R2 imm_valid", imm_valid, e_imv);
      chk("R3 immediate value", imm, e_imm);
      chk("R7 br_valid", br_valid, e_brv);
      chk("R6 br_taken", br_taken, e_tk);
      if (e_tk) chk("R5 taken target", next_pc, e_next);
      else      chk("R6 fall-through next_pc", next_pc, e_next);
   endtask

   logic [15:0] pcs  [4] = '{16'h0000, 16'h1234, 16'hFF80, 16'hFFFE};
   logic [7:0]  vals [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset busy/done/req", {busy, done, mem_req}, 0);
      chk("R10 reset results", {ea_valid, imm_valid, br_valid, br_taken}, 0);
      chk("R10 reset values", {ea, next_pc}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // main sweep
      for (int m = 0; m < 8; m++)
         for (int pi = 0; pi < 4; pi++)
            for (int ai = 0; ai < 6; ai++)
               for (int bi = 0; bi < 6; bi++)
                  for (int c = 0; c < 2; c++)
                     run_one(3'(m), pcs[pi], vals[ai], vals[bi], 1'(c));

      // R5 specific offsets
      run_one(3'd4, 16'h1000, 8'h7F, 8'h00, 1'b1);
      chk("R5 offset 0x7F", next_pc, 16'h1081);
      run_one(3'd4, 16'h1000, 8'h80, 8'h00, 1'b1);
      chk("R5 offset 0x80", next_pc, 16'h0F82);
      run_one(3'd4, 16'hFFFE, 8'h05, 8'h00, 1'b1);
      chk("R5 wrap past top", next_pc, 16'h0005);

      // R8 start ignored while busy, busy timing
      cur_pc = 16'h2000; x1 = 8'hAB; x2 = 8'hCD; reads = 0; bad_addr = 0;
      @(negedge clk);
      mode = 3'd2; pc = 16'h2000; cond = 1'b0; start = 1'b1;
      @(negedge clk);
      chk("R8 busy after accept", busy, 1'b1);
      mode = 3'd0; pc = 16'h5555; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 12) begin
         @(negedge clk);
         lat++;
      end
      chk("R8 second start ignored imm", imm, 16'hABCD);
      chk("R8 second start ignored next_pc", next_pc, 16'h2003);
      chk("R8 busy low at done", busy, 1'b0);

      // R11 hold after done
      repeat (4) @(negedge clk);
      chk("R11 done is a pulse", done, 1'b0);
      chk("R11 imm held", imm, 16'hABCD);
      chk("R11 next_pc held", next_pc, 16'h2003);
      chk("R11 no stray reads", reads, 2);

      summary();
      $finish;
   end

endmodule